// File: doc/BRIEF.md
# I2C Bit-Rate Setting Calculator

This block turns a pair of frequencies into the divider setting of an I2C master clock generator. The inputs are the system clock frequency and the requested bus frequency. The outputs are an 8-bit rate value and a 2-bit prescaler exponent. A clock generator driven by these outputs gives an SCL period of 16 + 2·rate·4^prescaler system clocks.

Raise `start_i` for one cycle. The block latches both frequencies and works out their integer ratio with a restoring divider, one quotient bit per cycle. From the quotient it forms a base value. It then tries the prescaler exponents from smallest to largest, one per cycle, until the value fits in the rate field. When the result is ready, `done_o` pulses for one cycle. The result stays on the outputs until the next accepted request.

A request for a bus frequency of zero needs no division. It returns the slowest setting at once and raises a flag.

Top module: `i2c_rate_calc`

## Requirements
- R1: After a synchronous active-low reset, `rate_o`, `prescale_o`, `done_o`, `busy_o` and `zero_req_o` are all 0.
- R2: A `start_i` pulse while idle with a nonzero bus frequency latches both frequencies and raises `busy_o` in the next cycle.
- R3: The base value is floor((Q − 16) / 2), where Q = floor(sys_freq / bus_freq). When Q is below 16, the base value is 0.
- R4: The exponents are tried in the order 0, 1, 2, 3. Before each next try the value is replaced by floor(value / 4). The result is the first exponent whose value is at most 255, together with that value as the rate.
- R5: When the value still exceeds 255 at exponent 3, the result is rate 255 with prescaler 3.
- R6: A request with bus frequency 0 returns rate 255, prescaler 3 and `zero_req_o` = 1, with `done_o` in the cycle right after the start. `busy_o` stays low. The next nonzero request clears `zero_req_o`.
- R7: `done_o` is high for exactly one cycle per accepted request. `rate_o`, `prescale_o` and `zero_req_o` change only in a cycle where `done_o` is high, and they hold otherwise.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running request finishes with its own result.
- R9: Changes on the frequency inputs after the start cycle do not affect the result of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| sys_freq_i | input | SYS_W (32) | System clock frequency |
| bus_freq_i | input | REQ_W (32) | Requested bus frequency |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| rate_o | output | RATE_W (8) | Bit-rate value |
| prescale_o | output | PRE_W (2) | Prescaler exponent |
| zero_req_o | output | 1 | Last result came from a zero bus frequency request |

## Verification
The assertions check on every cycle that `done_o` is a single-cycle pulse that never coincides with `busy_o`. They also check that the outputs move only with `done_o`, that a zero request always yields the slowest setting, and that the search stops at the first exponent that fits. They check that the divider step count stays in range. The arithmetic of the result can only be shown by the bench's scenarios. Those cover the clamp below a ratio of 16, the 255/256 boundary at each exponent, saturation, a divisor larger than the dividend, and operands that change or a start that is repeated mid-run.

// File: rtl/i2c_rate_pkg.sv
// Package: shared types and constants of the bit-rate calculator.
// Assumes: imported by every module of the calculator.
package i2c_rate_pkg;

    // Fixed SCL overhead, in system clocks, subtracted from the ratio.
    localparam int unsigned SCL_OVERHEAD = 16;

    typedef enum logic [1:0] {
        CALC_IDLE   = 2'd0,
        CALC_DIVIDE = 2'd1,
        CALC_SEARCH = 2'd2
    } calc_state_e;

endpackage

// File: rtl/rate_divider.sv
// Module: restoring unsigned divider that makes one quotient bit per cycle.
// Assumes: the divisor is nonzero (the caller filters a zero divisor).
// The quotient is valid in the cycle where done_o is high, and it holds
// until the next start.
module rate_divider #(
    parameter int unsigned NUM_W = 32,
    parameter int unsigned DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);
    localparam int unsigned CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;
    logic             unused_diff_msb;

    // Purpose: form the shifted partial remainder and compare it with the divisor.
    always_comb begin
        trial = {rem_q, num_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end
    assign unused_diff_msb = diff[DEN_W];

    // Purpose: load the operands, then shift one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                num_q  <= num_i;
                den_q  <= den_i;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                num_q <= {num_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign quot_o = num_q;

    // R3: a running division always has steps left to do.
    a_r3_div_steps_left: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0));

    // R3: the divider ends one step after its count reaches one.
    a_r3_div_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == CNT_W'(1)) |=> (done_q && !busy_q));

endmodule

// File: rtl/prescale_search.sv
// Module: tries the prescaler exponents in ascending order, one per cycle,
// dividing the value by four between tries, and saturates at the largest
// exponent.
// Assumes: VAL_W is wider than RATE_W.
module prescale_search #(
    parameter int unsigned VAL_W  = 32,
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PRE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VAL_W-1:0]  value_i,
    output logic              done_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [PRE_W-1:0]  pre_o
);
    localparam logic [RATE_W-1:0] RATE_MAX = {RATE_W{1'b1}};
    localparam logic [PRE_W-1:0]  PRE_MAX  = {PRE_W{1'b1}};
    localparam logic [VAL_W-1:0]  FIT_MAX  = VAL_W'(RATE_MAX);

    logic [VAL_W-1:0]  cur_q;
    logic [PRE_W-1:0]  exp_q;
    logic              busy_q;
    logic              done_q;
    logic [RATE_W-1:0] rate_q;
    logic [PRE_W-1:0]  pre_q;
    logic              fits;

    // Purpose: decide whether the current value fits in the rate field.
    always_comb fits = (cur_q <= FIT_MAX);

    // Purpose: step through the exponents until one fits or none are left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            exp_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rate_q <= '0;
            pre_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                cur_q  <= value_i;
                exp_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rate_q <= cur_q[RATE_W-1:0];
                    pre_q  <= exp_q;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else if (exp_q == PRE_MAX) begin
                    rate_q <= RATE_MAX;
                    pre_q  <= PRE_MAX;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cur_q <= cur_q >> 2;
                    exp_q <= exp_q + 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign rate_o = rate_q;
    assign pre_o  = pre_q;

    // R4: a value that fits ends the search with the exponent being tried.
    a_r4_first_fit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && fits) |=> (done_q && pre_q == $past(exp_q)));

    // R5: running out of exponents gives the slowest setting.
    a_r5_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fits && exp_q == PRE_MAX) |=> (rate_q == RATE_MAX && pre_q == PRE_MAX));

endmodule

// File: rtl/i2c_rate_calc.sv
// Module: top of the I2C bit-rate calculator. It sequences the divider and
// the prescaler search, handles a zero bus frequency, and holds the result.
// Assumes: start_i is a pulse. A start while busy is ignored.
module i2c_rate_calc
    import i2c_rate_pkg::*;
#(
    parameter int unsigned SYS_W  = 32,
    parameter int unsigned REQ_W  = 32,
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PRE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SYS_W-1:0]  sys_freq_i,
    input  logic [REQ_W-1:0]  bus_freq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [PRE_W-1:0]  prescale_o,
    output logic              zero_req_o
);
    localparam logic [SYS_W-1:0]  OVERHEAD = SYS_W'(SCL_OVERHEAD);
    localparam logic [RATE_W-1:0] RATE_MAX = {RATE_W{1'b1}};
    localparam logic [PRE_W-1:0]  PRE_MAX  = {PRE_W{1'b1}};

    calc_state_e       state_q;
    logic              done_q;
    logic              zero_q;
    logic [RATE_W-1:0] rate_q;
    logic [PRE_W-1:0]  pre_q;
    logic              accept;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [SYS_W-1:0]  div_quot;
    logic [SYS_W-1:0]  base_val;
    logic              srch_done;
    logic [RATE_W-1:0] srch_rate;
    logic [PRE_W-1:0]  srch_pre;
    logic              unused_div_busy;

    // Purpose: accept a request only while idle, and send nonzero ones to the divider.
    always_comb begin
        accept    = start_i && (state_q == CALC_IDLE);
        div_start = accept && (bus_freq_i != '0);
    end

    // Purpose: subtract the overhead from the quotient and halve it, clamping at zero.
    always_comb begin
        if (div_quot < OVERHEAD) base_val = '0;
        else                     base_val = (div_quot - OVERHEAD) >> 1;
    end

    rate_divider #(
        .NUM_W (SYS_W),
        .DEN_W (REQ_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (sys_freq_i),
        .den_i   (bus_freq_i),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );
    assign unused_div_busy = div_busy;

    prescale_search #(
        .VAL_W  (SYS_W),
        .RATE_W (RATE_W),
        .PRE_W  (PRE_W)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_done),
        .value_i (base_val),
        .done_o  (srch_done),
        .rate_o  (srch_rate),
        .pre_o   (srch_pre)
    );

    // Purpose: control sequencing, capture the result and make the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CALC_IDLE;
            done_q  <= 1'b0;
            zero_q  <= 1'b0;
            rate_q  <= '0;
            pre_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                CALC_IDLE: begin
                    if (accept && bus_freq_i == '0) begin
                        rate_q <= RATE_MAX;
                        pre_q  <= PRE_MAX;
                        zero_q <= 1'b1;
                        done_q <= 1'b1;
                    end else if (accept) begin
                        state_q <= CALC_DIVIDE;
                    end
                end
                CALC_DIVIDE: begin
                    if (div_done) state_q <= CALC_SEARCH;
                end
                CALC_SEARCH: begin
                    if (srch_done) begin
                        rate_q  <= srch_rate;
                        pre_q   <= srch_pre;
                        zero_q  <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= CALC_IDLE;
                    end
                end
                default: state_q <= CALC_IDLE;
            endcase
        end
    end

    assign busy_o     = (state_q != CALC_IDLE);
    assign done_o     = done_q;
    assign rate_o     = rate_q;
    assign prescale_o = pre_q;
    assign zero_req_o = zero_q;

    // R7: done lasts a single cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done is never raised while the block is busy.
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7: the result outputs hold except in a done cycle.
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(rate_o) && $stable(prescale_o) && $stable(zero_req_o)));

    // R6: a zero request always reports the slowest setting.
    a_r6_zero_slowest: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_req_o) |-> (rate_o == RATE_MAX && prescale_o == PRE_MAX));

    // R6: a zero request finishes in the next cycle without going busy.
    a_r6_zero_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_freq_i == '0) |=> (done_o && !busy_o));

endmodule

// File: tb/sim_i2c_rate_calc.sv
`timescale 1ns/1ps
module sim_i2c_rate_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] sys_f = '0;
    logic [31:0] bus_f = '0;
    logic        busy, done, zflag;
    logic [7:0]  rate;
    logic [1:0]  pre;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_rate_calc u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .sys_freq_i (sys_f),
        .bus_freq_i (bus_f),
        .busy_o     (busy),
        .done_o     (done),
        .rate_o     (rate),
        .prescale_o (pre),
        .zero_req_o (zflag)
    );

    // {sys_freq, bus_freq, expected rate, expected prescaler}, worked out by hand.
    localparam int NV = 17;
    localparam logic [73:0] VEC [NV] = '{
        {32'd16000000, 32'd100000,  8'd72,  2'd0},  // R3 ratio 160
        {32'd16000000, 32'd400000,  8'd12,  2'd0},  // R3 ratio 40
        {32'd16000000, 32'd1000000, 8'd0,   2'd0},  // R3 ratio 16 exactly
        {32'd16000000, 32'd2000000, 8'd0,   2'd0},  // R3 ratio 8, clamp
        {32'd100,      32'd200,     8'd0,   2'd0},  // R3 divisor above dividend
        {32'd17,       32'd1,       8'd0,   2'd0},  // R3 odd remainder dropped
        {32'd36,       32'd2,       8'd1,   2'd0},  // R3 ratio 18
        {32'd526,      32'd1,       8'd255, 2'd0},  // R4 base 255 fits at 0
        {32'd1581,     32'd3,       8'd255, 2'd0},  // R4 ratio 527, base 255
        {32'd528,      32'd1,       8'd64,  2'd1},  // R4 base 256 -> exp 1
        {32'd16000000, 32'd10000,   8'd198, 2'd1},  // R4 792 -> 198
        {32'd8206,     32'd1,       8'd255, 2'd2},  // R4 4095 -> 255 at exp 2
        {32'd16000000, 32'd1000,    8'd124, 2'd3},  // R4 7992 -> 124 at exp 3
        {32'd16000000, 32'd500,     8'd249, 2'd3},  // R4 15992 -> 249 at exp 3
        {32'd32782,    32'd1,       8'd255, 2'd3},  // R4 16383 just fits at exp 3
        {32'd16000000, 32'd100,     8'd255, 2'd3},  // R5 saturation
        {32'hFFFFFFFF, 32'd1,       8'd255, 2'd3}   // R5 largest ratio
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] fs, input logic [31:0] fb);
        @(negedge clk);
        sys_f = fs;
        bus_f = fb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [7:0] held_rate;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rate", 32'(rate), 0);
        check("R1 prescale", 32'(pre), 0);
        check("R1 done", 32'(done), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 zero flag", 32'(zflag), 0);
        rst_n = 1'b1;

        // Table walk: R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][73:42], VEC[i][41:10]);
            wait_done(cyc);
            check("R7 done seen", 32'(done), 1);
            check("R3/R4/R5 rate", 32'(rate), 32'(VEC[i][9:2]));
            check("R4/R5 prescale", 32'(pre), 32'(VEC[i][1:0]));
            check("R6 zero flag low", 32'(zflag), 0);
            @(negedge clk);
            check("R7 done one cycle", 32'(done), 0);
        end

        // R2: busy after start; R7: hold after done
        launch(32'd16000000, 32'd400000);
        check("R2 busy after start", 32'(busy), 1);
        wait_done(cyc);
        held_rate = rate;
        repeat (5) @(negedge clk);
        check("R7 rate held", 32'(rate), 32'(held_rate));
        check("R7 no extra done", 32'(done), 0);

        // R6: zero request
        launch(32'd1000, 32'd0);
        check("R6 done next cycle", 32'(done), 1);
        check("R6 not busy", 32'(busy), 0);
        check("R6 rate", 32'(rate), 255);
        check("R6 prescale", 32'(pre), 3);
        check("R6 flag set", 32'(zflag), 1);
        launch(32'd16000000, 32'd100000);
        wait_done(cyc);
        check("R6 flag cleared", 32'(zflag), 0);
        check("R6 next rate", 32'(rate), 72);

        // R8: start while busy is ignored
        launch(32'd16000000, 32'd1000);
        repeat (3) @(negedge clk);
        sys_f = 32'd16000000;
        bus_f = 32'd400000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check("R8 rate of first request", 32'(rate), 124);
        check("R8 prescale of first request", 32'(pre), 3);
        repeat (3) @(negedge clk);
        check("R8 no second done", 32'(done), 0);
        check("R8 idle after", 32'(busy), 0);

        // R9: inputs changed after the start cycle
        launch(32'd16000000, 32'd10000);
        sys_f = 32'd5;
        bus_f = 32'd0;
        wait_done(cyc);
        check("R9 rate", 32'(rate), 198);
        check("R9 prescale", 32'(pre), 1);
        check("R9 zero flag", 32'(zflag), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule